// File: doc/BRIEF.md
# Oversampled Bit Clock Recovery Loop

This block pulls a channel bit clock out of a sliced, oversampled bit stream and uses it to re-sample the data near the middle of each bit. It advances one step per fast-clock cycle, so every cycle sees exactly one oversampled input bit. A wide phase accumulator serves as the oscillator. Whenever its sum overflows, that cycle is taken as the sampling instant. A phase detector records how far the accumulator sits from half scale whenever the input toggles. A proportional-plus-integral loop filter turns that error into a correction of the frequency word.

Software supplies the nominal frequency word, the two gain shifts, a saturation window for the applied word and a lock threshold. A single enable selects closed-loop tracking. With the enable low, the oscillator free-runs at the nominal word, and any frequency offset shows up as a ramp in the reported phase error. The block brings out the re-sampled bit and its strobe, the held phase error, and a lock flag.

Top module: `cdr_nco_pll`

## Requirements
- R1: After reset the accumulator is zero. On every active cycle it adds the applied frequency word, modulo 2^ACC_W.
- R2: A cycle whose addition carries out of the accumulator is a sampling instant. On the following cycle `bit_stb` is 1 and `bit_out` carries `din` as it stood in the sampling cycle. In all other cycles `bit_stb` is 0 and `bit_out` keeps its value.
- R3: In a cycle where `din` differs from its value in the previous cycle, `phase_err` takes the value (2^(ACC_W-1) − accumulator), computed modulo 2^ACC_W and read as two's complement. The accumulator value used is the one before that cycle's addition, and the new error is visible one cycle later.
- R4: `phase_err` is zero after reset and keeps its last value through cycles without an input transition.
- R5: With `loop_en` = 1 and a data rate within about 0.1 % of the nominal word, the loop settles so that the strobe rate equals the data bit rate and |`phase_err`| falls below 2^(ACC_W-4). The loop uses a first-order low-pass filter with a coefficient of 2^-8, a proportional term shifted right by `kp_shift`, and an integrator fed by the filtered error shifted right by `ki_shift`.
- R6: With `loop_en` = 0 the applied word equals `ftw_nom` exactly, whatever the gains and the saturation window are. The integrator is cleared.
- R7: With `loop_en` = 1 the applied word is (`ftw_nom` + proportional term + integrator), clamped to the range [`ftw_min`, `ftw_max`].
- R8: `lock` rises when LOCK_N (256) consecutive input transitions each find the magnitude of the filtered error below `lock_thr`. A transition that fails this test clears `lock`, and `lock` holds between transitions.
- R9: When a sampling instant and an input transition fall in the same cycle, both take effect. The sampled bit is the new `din` value, and the phase error uses the accumulator value from before that cycle's addition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, one oversampled bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| din | input | 1 | Sliced oversampled input bit |
| ftw_nom | input | ACC_W | Nominal (centre) frequency word |
| ftw_min | input | ACC_W | Lower clamp of applied word in closed loop |
| ftw_max | input | ACC_W | Upper clamp of applied word in closed loop |
| loop_en | input | 1 | 1 = closed loop, 0 = free-run at nominal word |
| kp_shift | input | SHIFT_W | Right shift for proportional term |
| ki_shift | input | SHIFT_W | Right shift for integrator input |
| lock_thr | input | ACC_W | Filtered-error magnitude threshold for lock |
| bit_out | output | 1 | Re-sampled data bit |
| bit_stb | output | 1 | One-cycle strobe marking a new `bit_out` |
| phase_err | output | ACC_W | Held phase error, two's complement |
| lock | output | 1 | Lock indicator |

## Verification
The two functions that can meet in one cycle are the accumulator overflow, which samples `din`, and an input transition, which captures the phase error. The bench toggles `din` pseudo-randomly across a sweep of nominal words, including words that overflow every cycle and a word of zero, in free-run mode. Its cycle model of the accumulator flags every cycle in which both events fall together. In those cycles the bench expects the sampled bit to be the newly driven value and the error to be half scale minus the accumulator value from before the addition.

// File: rtl/cdr_pkg.sv
package cdr_pkg;
  localparam int unsigned LPF_SHIFT = 8;
  localparam int unsigned DEF_ACC_W = 32;
  localparam int unsigned DEF_LOCK_N = 256;
  localparam int unsigned DEF_SHIFT_W = 5;

  typedef enum logic [1:0] {
    CLAMP_NONE = 2'd0,
    CLAMP_LOW  = 2'd1,
    CLAMP_HIGH = 2'd2
  } clamp_e;
endpackage

// File: rtl/cdr_nco.sv
module cdr_nco #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] ftw,
  input  logic             din,
  output logic [ACC_W-1:0] acc,
  output logic             bit_out,
  output logic             bit_stb
);
  logic [ACC_W:0]   sum;
  logic [ACC_W-1:0] acc_nxt;
  logic             wrap;
  logic             bit_nxt;

  always_comb begin
    sum     = {1'b0, acc} + {1'b0, ftw};
    acc_nxt = sum[ACC_W-1:0];
    wrap    = sum[ACC_W];
    bit_nxt = wrap ? din : bit_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      bit_out <= 1'b0;
      bit_stb <= 1'b0;
    end else begin
      acc     <= acc_nxt;
      bit_out <= bit_nxt;
      bit_stb <= wrap;
    end
  end

  // R2: a strobe marks a cycle in which the accumulator fell back
  a_r2_stb_means_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |-> (acc < $past(acc)));
  // R1: without a strobe the accumulator never decreased
  a_r1_no_stb_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |-> (acc >= $past(acc)));
  // R2: sampled bit only moves on a strobe
  a_r2_bit_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |-> $stable(bit_out));
endmodule

// File: rtl/cdr_phase_det.sv
module cdr_phase_det #(
  parameter int ACC_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    din,
  input  logic [ACC_W-1:0]        acc,
  output logic                    trans,
  output logic signed [ACC_W-1:0] perr
);
  localparam logic [ACC_W-1:0] HALF = {1'b1, {(ACC_W-1){1'b0}}};

  logic                    din_q;
  logic signed [ACC_W-1:0] perr_nxt;

  always_comb begin
    trans    = din ^ din_q;
    perr_nxt = trans ? $signed(HALF - acc) : perr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_q <= 1'b0;
      perr  <= '0;
    end else begin
      din_q <= din;
      perr  <= perr_nxt;
    end
  end

  // R4: no transition seen means the error is held
  a_r4_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (din_q == $past(din_q)) |-> $stable(perr));
endmodule

// File: rtl/cdr_loop_filter.sv
module cdr_loop_filter
  import cdr_pkg::*;
#(
  parameter int ACC_W   = 32,
  parameter int SHIFT_W = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [ACC_W-1:0] perr,
  input  logic [ACC_W-1:0]        ftw_nom,
  input  logic [ACC_W-1:0]        ftw_min,
  input  logic [ACC_W-1:0]        ftw_max,
  input  logic                    loop_en,
  input  logic [SHIFT_W-1:0]      kp_shift,
  input  logic [SHIFT_W-1:0]      ki_shift,
  output logic signed [ACC_W-1:0] filt,
  output logic [ACC_W-1:0]        ftw_app
);
  localparam int EW = ACC_W + 2;
  localparam logic signed [ACC_W-1:0] I_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] I_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W-1:0] integ;
  logic signed [ACC_W:0]   diff;
  logic signed [ACC_W:0]   lp_step;
  logic signed [ACC_W-1:0] filt_nxt;
  logic signed [ACC_W-1:0] i_inc;
  logic signed [ACC_W:0]   i_sum;
  logic signed [ACC_W-1:0] i_sat;
  logic signed [ACC_W-1:0] integ_nxt;
  logic signed [ACC_W-1:0] prop;
  logic signed [EW-1:0]    total;
  clamp_e                  clamp;

  always_comb begin
    diff     = $signed({perr[ACC_W-1], perr}) - $signed({filt[ACC_W-1], filt});
    lp_step  = diff >>> LPF_SHIFT;
    filt_nxt = filt + $signed(lp_step[ACC_W-1:0]);

    i_inc = filt >>> ki_shift;
    i_sum = $signed({integ[ACC_W-1], integ}) + $signed({i_inc[ACC_W-1], i_inc});
    if (i_sum[ACC_W] != i_sum[ACC_W-1]) begin
      i_sat = i_sum[ACC_W] ? I_MIN : I_MAX;
    end else begin
      i_sat = $signed(i_sum[ACC_W-1:0]);
    end
    integ_nxt = loop_en ? i_sat : '0;

    prop  = filt >>> kp_shift;
    total = $signed({2'b00, ftw_nom})
          + $signed({{2{prop[ACC_W-1]}}, prop})
          + $signed({{2{integ[ACC_W-1]}}, integ});
    if (total < $signed({2'b00, ftw_min})) begin
      clamp = CLAMP_LOW;
    end else if (total > $signed({2'b00, ftw_max})) begin
      clamp = CLAMP_HIGH;
    end else begin
      clamp = CLAMP_NONE;
    end

    if (!loop_en) begin
      ftw_app = ftw_nom;
    end else begin
      case (clamp)
        CLAMP_LOW:  ftw_app = ftw_min;
        CLAMP_HIGH: ftw_app = ftw_max;
        default:    ftw_app = total[ACC_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt  <= '0;
      integ <= '0;
    end else begin
      filt  <= filt_nxt;
      integ <= integ_nxt;
    end
  end

  // R6: leaving closed loop empties the integrator
  a_r6_integ_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(loop_en) |=> (integ == '0));
  // R7: closed-loop word stays inside a well-formed window
  a_r7_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_en && (ftw_min <= ftw_max)) |-> ((ftw_app >= ftw_min) && (ftw_app <= ftw_max)));
endmodule

// File: rtl/cdr_lock_det.sv
module cdr_lock_det #(
  parameter int ACC_W  = 32,
  parameter int LOCK_N = 256
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    trans,
  input  logic signed [ACC_W-1:0] filt,
  input  logic [ACC_W-1:0]        lock_thr,
  output logic                    lock
);
  localparam int CW = $clog2(LOCK_N + 1);
  localparam logic [CW-1:0] LOCK_V = CW'(LOCK_N);

  logic [CW-1:0]  cnt;
  logic [CW-1:0]  cnt_nxt;
  logic           lock_nxt;
  logic [ACC_W:0] fx;
  logic [ACC_W:0] mag;
  logic           good;

  always_comb begin
    fx   = {filt[ACC_W-1], filt};
    mag  = fx[ACC_W] ? (~fx + {{ACC_W{1'b0}}, 1'b1}) : fx;
    good = mag < {1'b0, lock_thr};
    cnt_nxt  = cnt;
    lock_nxt = lock;
    if (trans) begin
      if (!good) begin
        cnt_nxt = '0;
      end else if (cnt != LOCK_V) begin
        cnt_nxt = cnt + 1'b1;
      end
      lock_nxt = (cnt_nxt == LOCK_V);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      lock <= 1'b0;
    end else begin
      cnt  <= cnt_nxt;
      lock <= lock_nxt;
    end
  end

  // R8: lock can only rise on a transition
  a_r8_rise_on_trans: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(trans));
  // R8: lock holds between transitions
  a_r8_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(trans) |-> $stable(lock));
endmodule

// File: rtl/cdr_nco_pll.sv
module cdr_nco_pll
  import cdr_pkg::*;
#(
  parameter int ACC_W   = DEF_ACC_W,
  parameter int SHIFT_W = DEF_SHIFT_W,
  parameter int LOCK_N  = DEF_LOCK_N
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               din,
  input  logic [ACC_W-1:0]   ftw_nom,
  input  logic [ACC_W-1:0]   ftw_min,
  input  logic [ACC_W-1:0]   ftw_max,
  input  logic               loop_en,
  input  logic [SHIFT_W-1:0] kp_shift,
  input  logic [SHIFT_W-1:0] ki_shift,
  input  logic [ACC_W-1:0]   lock_thr,
  output logic               bit_out,
  output logic               bit_stb,
  output logic [ACC_W-1:0]   phase_err,
  output logic               lock
);
  logic                    rst_meta;
  logic                    rst_s;
  logic [ACC_W-1:0]        acc;
  logic [ACC_W-1:0]        ftw_app;
  logic                    trans;
  logic signed [ACC_W-1:0] perr;
  logic signed [ACC_W-1:0] filt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  cdr_nco #(.ACC_W(ACC_W)) u_nco (
    .clk(clk), .rst_n(rst_s), .ftw(ftw_app), .din(din),
    .acc(acc), .bit_out(bit_out), .bit_stb(bit_stb)
  );

  cdr_phase_det #(.ACC_W(ACC_W)) u_pd (
    .clk(clk), .rst_n(rst_s), .din(din), .acc(acc),
    .trans(trans), .perr(perr)
  );

  cdr_loop_filter #(.ACC_W(ACC_W), .SHIFT_W(SHIFT_W)) u_lf (
    .clk(clk), .rst_n(rst_s), .perr(perr), .ftw_nom(ftw_nom),
    .ftw_min(ftw_min), .ftw_max(ftw_max), .loop_en(loop_en),
    .kp_shift(kp_shift), .ki_shift(ki_shift), .filt(filt), .ftw_app(ftw_app)
  );

  cdr_lock_det #(.ACC_W(ACC_W), .LOCK_N(LOCK_N)) u_lock (
    .clk(clk), .rst_n(rst_s), .trans(trans), .filt(filt),
    .lock_thr(lock_thr), .lock(lock)
  );

  assign phase_err = perr;
endmodule

// File: tb/cdr_nco_pll_test.sv
`timescale 1ns/1ps
module cdr_nco_pll_test;
  localparam logic [31:0] HALF = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        din = 1'b0;
  logic [31:0] ftw_nom = 32'h0;
  logic [31:0] ftw_min = 32'h0;
  logic [31:0] ftw_max = 32'hFFFF_FFFF;
  logic        loop_en = 1'b0;
  logic [4:0]  kp_shift = 5'd0;
  logic [4:0]  ki_shift = 5'd0;
  logic [31:0] lock_thr = 32'd1;
  logic        bit_out;
  logic        bit_stb;
  logic [31:0] phase_err;
  logic        lock;

  always #2 clk = ~clk;

  cdr_nco_pll uut (
    .clk(clk), .rst_n(rst_n), .din(din), .ftw_nom(ftw_nom),
    .ftw_min(ftw_min), .ftw_max(ftw_max), .loop_en(loop_en),
    .kp_shift(kp_shift), .ki_shift(ki_shift), .lock_thr(lock_thr),
    .bit_out(bit_out), .bit_stb(bit_stb), .phase_err(phase_err), .lock(lock)
  );

  int          total = 0;
  int          bad = 0;
  int          coincide = 0;
  logic [31:0] acc_m, ftw_m, perr_m;
  logic        din_m, bit_m;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic lfsr_adv();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    din   = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    acc_m = '0; perr_m = '0; din_m = 1'b0; bit_m = 1'b0;
    check(bit_stb === 1'b0, "R1 reset strobe", {63'd0, bit_stb}, 0);
    check(phase_err === 32'h0, "R4 reset error", {32'd0, phase_err}, 0);
    check(lock === 1'b0, "R8 reset lock", {63'd0, lock}, 0);
  endtask

  // one modelled cycle: drive at negedge, check after the following posedge
  task automatic step(input logic d, input bit chk);
    logic [32:0] s;
    bit          tr;
    din = d;
    s   = {1'b0, acc_m} + {1'b0, ftw_m};
    tr  = (d != din_m);
    if (tr) perr_m = HALF - acc_m;
    if (s[32]) bit_m = d;
    if (tr && s[32]) coincide++;
    acc_m = s[31:0];
    din_m = d;
    @(negedge clk);
    if (chk) begin
      check(bit_stb === s[32], "R1 strobe on carry", {63'd0, bit_stb}, {63'd0, s[32]});
      check(bit_out === bit_m, (tr && s[32]) ? "R9 sampled bit" : "R2 sampled bit",
            {63'd0, bit_out}, {63'd0, bit_m});
      check(phase_err === perr_m, (tr && s[32]) ? "R9 error" : (tr ? "R3 error" : "R4 held error"),
            {32'd0, phase_err}, {32'd0, perr_m});
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] words [5];
    int          nt, gap, stb_cnt, run_left;
    logic        d;
    logic [31:0] mag;
    words[0] = 32'h4000_0000;
    words[1] = 32'h3000_0001;
    words[2] = 32'h1234_5678;
    words[3] = 32'hFFFF_FFFF;
    words[4] = 32'h0000_0000;

    // R6/R1/R2/R3/R4/R9: free-run sweep, window and gains must not matter
    for (int w = 0; w < 5; w++) begin
      loop_en = 1'b0; ftw_nom = words[w]; ftw_min = 32'd1; ftw_max = 32'd1;
      kp_shift = 5'd0; ki_shift = 5'd0;
      do_reset();
      ftw_m = words[w];
      for (int i = 0; i < 300; i++) begin
        lfsr_adv();
        step(din_m ^ (lfsr[1:0] == 2'b00), 1'b1);
      end
    end
    check(coincide > 0, "R9 coincidences provoked", 64'(coincide), 1);

    // R7: clamp to a single-point window with large gains and live errors
    loop_en = 1'b1; ftw_nom = 32'h4000_0000; ftw_min = 32'h2000_0000; ftw_max = 32'h2000_0000;
    kp_shift = 5'd0; ki_shift = 5'd0;
    do_reset();
    ftw_m = 32'h2000_0000;
    for (int i = 0; i < 200; i++) begin
      lfsr_adv();
      step(din_m ^ (lfsr[2:0] == 3'b000), 1'b1);
    end
    // R7: nominal below window, no transitions -> lower bound applies
    ftw_nom = 32'h1000_0000; ftw_min = 32'h3000_0000; ftw_max = 32'hFFFF_FFFF;
    do_reset();
    ftw_m = 32'h3000_0000;
    for (int i = 0; i < 100; i++) step(1'b0, 1'b1);
    // R7: nominal inside window, zero error -> nominal applies
    ftw_nom = 32'h5555_5555; ftw_min = 32'h1000_0000; ftw_max = 32'hF000_0000;
    do_reset();
    ftw_m = 32'h5555_5555;
    for (int i = 0; i < 100; i++) step(1'b0, 1'b1);

    // R8: lock after 256 centred transitions, hold, then loss
    loop_en = 1'b0; ftw_nom = 32'h2000_0000; lock_thr = 32'd1;
    do_reset();
    ftw_m = 32'h2000_0000;
    nt = 0; gap = 100;
    while (nt < 256) begin
      if (acc_m == HALF && gap >= 24) begin
        step(~din_m, 1'b1);
        nt++; gap = 0;
        check(lock === (nt == 256), "R8 lock after count", {63'd0, lock}, {63'd0, nt == 256});
      end else begin
        step(din_m, 1'b1);
        gap++;
      end
    end
    for (int i = 0; i < 40; i++) step(din_m, 1'b1);
    check(lock === 1'b1, "R8 lock holds quiet", {63'd0, lock}, 1);
    while (acc_m != 32'h0) step(din_m, 1'b1);
    step(~din_m, 1'b1);
    check(lock === 1'b1, "R8 off-centre edge sees old filter", {63'd0, lock}, 1);
    gap = 0;
    while (!(acc_m == HALF && gap >= 24)) begin step(din_m, 1'b1); gap++; end
    step(~din_m, 1'b1);
    check(lock === 1'b0, "R8 lock lost", {63'd0, lock}, 0);

    // R5: closed-loop tracking of a data stream 0.1 % faster than nominal
    loop_en = 1'b1; ftw_nom = 32'h2000_0000 - 32'h0008_0000;
    ftw_min = 32'h0; ftw_max = 32'hFFFF_FFFF; kp_shift = 5'd10; ki_shift = 5'd22;
    do_reset();
    d = 1'b0; run_left = 0; stb_cnt = 0;
    for (int c = 0; c < 90000; c++) begin
      if (run_left == 0) begin
        lfsr_adv();
        d = ~d;
        run_left = 8 * (3 + int'(lfsr[3:0]) % 9);
      end
      din = d;
      run_left--;
      @(negedge clk);
      if (c >= 82000 && bit_stb) stb_cnt++;
    end
    check(stb_cnt >= 999 && stb_cnt <= 1001, "R5 strobe rate matches data", 64'(stb_cnt), 1000);
    mag = phase_err[31] ? (~phase_err + 32'd1) : phase_err;
    check(mag < 32'h1000_0000, "R5 settled phase error", {32'd0, mag}, 32'h1000_0000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule